// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block turns a serial bit stream, qualified by a per-cycle bit-enable strobe, back into HDLC frames. It watches the line for the 01111110 flag, strips the zero that a sender inserts after five ones, and detects aborts (seven ones) and an idle line (fifteen ones). Each frame is checked against the 16-bit FCS and, when filtering is on, accepted or dropped according to its first byte. Every received byte of an accepted frame, FCS bytes included, leaves the block on a one-cycle strobe. The byte carries a start-of-frame tag on the first byte and an end-of-frame tag on the last. A bad tag on the last byte marks a failed frame.

The state machine has two states. In `S_HUNT` it ignores everything until a flag arrives (transition *open*: `S_HUNT` to `S_FRAME`). In `S_FRAME` it assembles bytes. A flag seen in `S_FRAME` closes the current frame and opens the next one without leaving the state (transition *close/reopen*). Seven ones in `S_FRAME` abandon the frame (transition *abort*: `S_FRAME` to `S_HUNT`). Bytes are sent least significant bit first. The block holds one byte back so that the tag of the last byte is known when the byte is presented.

The receive address, the filter enable and the six-bit compare control are plain inputs that are sampled when a frame's first byte completes.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Bit order and byte tags. Bits are collected least significant first into bytes, and each completed byte of an accepted frame is output once on `out_valid`, FCS bytes included. `out_sof` is set only on the first byte, and `out_eof` is set only on the byte presented when the frame ends.
- R2: Zero deletion. A zero that follows five consecutive ones inside a frame is removed and does not appear in any byte.
- R3: FCS check. The CRC is preset to 0xFFFF at every flag and updated LSB first with the reflected form of x^16+x^12+x^5+1 over the data and received FCS bits. A closing flag with a final value other than 0xF0B8 sets `out_bad` on the last byte.
- R4: Length and alignment. A frame closing with fewer than four bytes (FCS included), or with bits left over past a byte boundary, sets `out_bad` on its last byte.
- R5: Address filter. When `addr_filt_en` is 1, a frame is passed only if its first byte equals `my_addr` on bits 7..1 (bit 0 of `my_addr` is treated as 0 and address bit 0 is not compared) or is 0xFF. When `addr_filt_en` is 0, every frame is passed. A dropped frame produces no `out_valid`.
- R6: Six-bit compare. When `addr_six_bit` and `addr_filt_en` are both 1, only bits 7..2 are compared. `addr_six_bit` has no effect while `addr_filt_en` is 0.
- R7: Abort. Seven consecutive ones inside a frame drop it and return the block to flag hunting. A held byte of an accepted frame is then output with `out_eof` and `out_bad` set.
- R8: Abort indication. `frame_aborted` pulses for one cycle on an abort only if at least four bytes of the frame have completed. Otherwise it stays 0.
- R9: Idle. `line_idle` is 1 from the fifteenth consecutive one on the line and returns to 0 on the next zero.
- R10: Shared flag. One flag between two frames closes the first frame and opens the second, and both are delivered intact.
- R11: Repeated flags. Back-to-back flags with no data between them produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Serial line bit |
| rx_bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| my_addr | input | 8 | Station address for the filter |
| addr_filt_en | input | 1 | Enables address filtering |
| addr_six_bit | input | 1 | Narrows the compare to bits 7..2 when filtering |
| out_valid | output | 1 | Byte strobe |
| out_byte | output | 8 | Received byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_bad | output | 1 | Frame failed (FCS, length, alignment, or abort); valid with `out_eof` |
| frame_aborted | output | 1 | One-cycle pulse: abort after four or more bytes |
| line_idle | output | 1 | Fifteen or more consecutive ones seen |

## Verification
The bench builds the block with its default parameters: fifteen ones for idle, four-byte minimum frame and seven-bit flag lookahead. At these values the bench can sweep every one of the 256 address byte values through the filter, in both the seven-bit and the six-bit compare modes, with short frames. That sweep covers the broadcast value, the ignored low bit and the ignored bit 1. The same configuration keeps the idle and abort thresholds small enough to step through one bit at a time, on either side of each boundary.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [0:0] {
        S_HUNT  = 1'b0,
        S_FRAME = 1'b1
    } rx_state_t;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_REFL : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_bit_filter.sv
module hdlc_bit_filter #(
    parameter int IDLE_ONES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_valid,
    output logic flag_det,
    output logic stuff_det,
    output logic abort_det,
    output logic idle
);
    localparam int OW = $clog2(IDLE_ONES + 1);

    logic [OW-1:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (bit_valid) begin
            if (!bit_in)
                ones_q <= '0;
            else if (ones_q != OW'(IDLE_ONES))
                ones_q <= ones_q + 1'b1;
        end
    end

    always_comb begin
        flag_det  = bit_valid && !bit_in && (ones_q == OW'(6));
        stuff_det = bit_valid && !bit_in && (ones_q == OW'(5));
        abort_det = bit_valid &&  bit_in && (ones_q == OW'(6));
        idle      = (ones_q == OW'(IDLE_ONES));
    end

    // R2 / R7: a line bit is at most one of flag end, stuffed zero, abort
    a_r2_det_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_det, stuff_det, abort_det}));

    // R9: a zero on the line clears the idle status
    a_r9_zero_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_in) |=> !idle);

endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic shift_en,
    input  logic bit_in,
    output logic crc_ok
);
    import hdlc_rx_pkg::*;

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= CRC_PRESET;
        else if (init)
            crc_q <= CRC_PRESET;
        else if (shift_en)
            crc_q <= crc_step(crc_q, bit_in);
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match (
    input  logic [7:0] addr_byte,
    input  logic [7:0] station,
    input  logic       filt_en,
    input  logic       six_bit,
    output logic       accept
);
    logic [7:0] mask;

    always_comb begin
        mask   = (six_bit && filt_en) ? 8'hFC : 8'hFE;
        accept = !filt_en
              || (addr_byte == 8'hFF)
              || (((addr_byte ^ station) & mask) == 8'h00);
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
    parameter int IDLE_ONES = 15,
    parameter int MIN_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       rx_bit_en,
    input  logic [7:0] my_addr,
    input  logic       addr_filt_en,
    input  logic       addr_six_bit,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_bad,
    output logic       frame_aborted,
    output logic       line_idle
);
    import hdlc_rx_pkg::*;

    localparam int LAG = 7;
    localparam int CW  = $clog2(MIN_BYTES + 1);

    rx_state_t state_q, state_d;

    logic          flag_det, stuff_det, abort_det;
    logic          crc_ok, acc_now;
    logic [LAG-1:0] dly_q;
    logic [2:0]    fill_q;
    logic [6:0]    sr_q;
    logic [2:0]    bitcnt_q;
    logic [CW-1:0] bytecnt_q;
    logic [7:0]    held_q;
    logic          held_v_q, held_first_q, accept_q;
    logic          data_bit, commit, byte_done, close, abrt;
    logic [7:0]    new_byte;

    hdlc_bit_filter #(.IDLE_ONES(IDLE_ONES)) u_bits (
        .clk(clk), .rst_n(rst_n), .bit_in(rx_bit), .bit_valid(rx_bit_en),
        .flag_det(flag_det), .stuff_det(stuff_det), .abort_det(abort_det),
        .idle(line_idle)
    );

    hdlc_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .init(flag_det), .shift_en(commit),
        .bit_in(dly_q[0]), .crc_ok(crc_ok)
    );

    hdlc_addr_match u_addr (
        .addr_byte(new_byte), .station(my_addr), .filt_en(addr_filt_en),
        .six_bit(addr_six_bit), .accept(acc_now)
    );

    always_comb begin
        data_bit  = rx_bit_en && !flag_det && !stuff_det && !abort_det
                 && (state_q == S_FRAME);
        commit    = data_bit && (fill_q == 3'(LAG));
        byte_done = commit && (bitcnt_q == 3'd7);
        new_byte  = {dly_q[0], sr_q};
        close     = (state_q == S_FRAME) && flag_det;
        abrt      = (state_q == S_FRAME) && abort_det;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT:  if (flag_det)  state_d = S_FRAME;
            S_FRAME: if (abort_det) state_d = S_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0; fill_q <= '0; sr_q <= '0; bitcnt_q <= '0;
            bytecnt_q <= '0; held_q <= '0; held_v_q <= 1'b0;
            held_first_q <= 1'b0; accept_q <= 1'b0;
            out_valid <= 1'b0; out_byte <= '0; out_sof <= 1'b0;
            out_eof <= 1'b0; out_bad <= 1'b0; frame_aborted <= 1'b0;
        end else begin
            out_valid     <= 1'b0;
            out_sof       <= 1'b0;
            out_eof       <= 1'b0;
            out_bad       <= 1'b0;
            frame_aborted <= 1'b0;
            if (flag_det && (state_q == S_HUNT || close)) begin
                if (close && held_v_q && accept_q) begin
                    out_valid <= 1'b1;
                    out_byte  <= held_q;
                    out_sof   <= held_first_q;
                    out_eof   <= 1'b1;
                    out_bad   <= (bitcnt_q != 3'd0)
                              || (bytecnt_q < CW'(MIN_BYTES)) || !crc_ok;
                end
                fill_q    <= '0;
                bitcnt_q  <= '0;
                bytecnt_q <= '0;
                held_v_q  <= 1'b0;
            end else if (abrt) begin
                if (held_v_q && accept_q) begin
                    out_valid <= 1'b1;
                    out_byte  <= held_q;
                    out_sof   <= held_first_q;
                    out_eof   <= 1'b1;
                    out_bad   <= 1'b1;
                end
                frame_aborted <= (bytecnt_q == CW'(MIN_BYTES));
                held_v_q      <= 1'b0;
            end else if (data_bit) begin
                dly_q <= {rx_bit, dly_q[LAG-1:1]};
                if (fill_q != 3'(LAG)) fill_q <= fill_q + 3'd1;
                if (commit) begin
                    sr_q     <= {dly_q[0], sr_q[6:1]};
                    bitcnt_q <= bitcnt_q + 3'd1;
                end
                if (byte_done) begin
                    if (bytecnt_q != CW'(MIN_BYTES)) bytecnt_q <= bytecnt_q + 1'b1;
                    if (bytecnt_q == '0) accept_q <= acc_now;
                    if (held_v_q && accept_q) begin
                        out_valid <= 1'b1;
                        out_byte  <= held_q;
                        out_sof   <= held_first_q;
                    end
                    held_q       <= new_byte;
                    held_v_q     <= 1'b1;
                    held_first_q <= (bytecnt_q == '0);
                end
            end
        end
    end

    // R1: a frame end is never followed by a byte in the very next cycle
    a_r1_gap_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |=> !out_valid);

    // R4: a good end-of-frame needs the minimum byte count
    a_r4_good_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof && !out_bad) |-> ($past(bytecnt_q) == CW'(MIN_BYTES)));

    // R7: after an abort pulse the block is hunting for a flag
    a_r7_hunt_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        frame_aborted |-> (state_q == S_HUNT));

    // R8: an abort pulse only comes out of an open frame
    a_r8_abort_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_aborted |-> ($past(state_q) == S_FRAME));

endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic rx_bit_en = 1'b0;
    logic [7:0] my_addr = 8'h00;
    logic addr_filt_en = 1'b0;
    logic addr_six_bit = 1'b0;
    logic out_valid, out_sof, out_eof, out_bad, frame_aborted, line_idle;
    logic [7:0] out_byte;

    always #2.5 clk = ~clk;

    hdlc_rx_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .my_addr(my_addr), .addr_filt_en(addr_filt_en), .addr_six_bit(addr_six_bit),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
        .out_eof(out_eof), .out_bad(out_bad), .frame_aborted(frame_aborted),
        .line_idle(line_idle)
    );

    int errors = 0, checks = 0, cycles = 0;
    int stuff_ones = 0;
    logic [7:0] tx [0:15];
    int tx_n = 0;
    logic [7:0] cap_d [0:63];
    logic cap_sof [0:63], cap_eof [0:63], cap_bad [0:63];
    int cap_n = 0, abort_cnt = 0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (out_valid && cap_n < 64) begin
                cap_d[cap_n]   <= out_byte;
                cap_sof[cap_n] <= out_sof;
                cap_eof[cap_n] <= out_eof;
                cap_bad[cap_n] <= out_bad;
                cap_n <= cap_n + 1;
            end
            if (frame_aborted) abort_cnt <= abort_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_bit_en = 1'b1;
    endtask

    task automatic pause(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit_en = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic send_stuffed(input logic b);
        send_bit(b);
        if (b) begin
            stuff_ones++;
            if (stuff_ones == 5) begin
                send_bit(1'b0);
                stuff_ones = 0;
            end
        end else begin
            stuff_ones = 0;
        end
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit((8'h7E >> i) & 1);
        stuff_ones = 0;
    endtask

    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++)
                c = (c >> 1) ^ (((c[0] ^ tx[k][i]) == 1'b1) ? 16'h8408 : 16'h0000);
        return c;
    endfunction

    // sends tx[0..tx_n-1] plus FCS; FCS appended to tx[] for comparison
    task automatic send_body(input bit corrupt);
        logic [15:0] fcs;
        fcs = ~crc_of(tx_n);
        if (corrupt) fcs[3] = ~fcs[3];
        tx[tx_n] = fcs[7:0];
        tx[tx_n+1] = fcs[15:8];
        for (int k = 0; k < tx_n + 2; k++)
            for (int i = 0; i < 8; i++) send_stuffed(tx[k][i]);
    endtask

    task automatic one_frame(input bit corrupt);
        cap_n = 0;
        send_flag();
        send_body(corrupt);
        send_flag();
        pause(3);
    endtask

    task automatic check_frame(input bit exp_acc, input bit exp_bad, input string req);
        int total;
        int mism;
        total = exp_acc ? tx_n + 2 : 0;
        chk(cap_n == total, {req, " byte count"}, cap_n, total);
        if (exp_acc && cap_n == total) begin
            mism = 0;
            for (int k = 0; k < total; k++)
                if (cap_d[k] !== tx[k] || cap_sof[k] !== (k == 0) ||
                    cap_eof[k] !== (k == total - 1)) mism++;
            chk(mism == 0, {req, " bytes/tags"}, mism, 0);
            chk(cap_bad[total-1] === exp_bad, {req, " bad flag"},
                int'(cap_bad[total-1]), int'(exp_bad));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ab0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && line_idle === 1'b0 && frame_aborted === 1'b0,
            "reset outputs", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: plain frame, filter off
        tx[0] = 8'h12; tx[1] = 8'h03; tx[2] = 8'hA7; tx[3] = 8'h5C; tx_n = 4;
        one_frame(0);
        check_frame(1, 0, "R1 plain");

        // R2: payload full of ones forces zero insertion
        tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h7E; tx[3] = 8'hBE; tx[4] = 8'h1F; tx_n = 5;
        one_frame(0);
        check_frame(1, 0, "R2 destuff");

        // R3: corrupted FCS
        tx[0] = 8'h40; tx[1] = 8'h99; tx[2] = 8'h01; tx_n = 3;
        one_frame(1);
        check_frame(1, 1, "R3 bad fcs");

        // R4: too short (3 bytes incl FCS) with a correct FCS
        tx[0] = 8'h21; tx_n = 1;
        one_frame(0);
        check_frame(1, 1, "R4 short");

        // R4: three bits past a byte boundary
        tx[0] = 8'h33; tx[1] = 8'h44; tx[2] = 8'h55; tx_n = 3;
        cap_n = 0;
        send_flag();
        send_body(0);
        send_stuffed(0); send_stuffed(1); send_stuffed(0);
        send_flag();
        pause(3);
        check_frame(1, 1, "R4 partial");

        // R10: two frames sharing one flag
        tx[0] = 8'h0F; tx[1] = 8'hF0; tx_n = 2;
        cap_n = 0;
        send_flag();
        send_body(0);
        send_flag();
        send_body(0);
        send_flag();
        pause(3);
        chk(cap_n == 8, "R10 shared flag count", cap_n, 8);
        chk(cap_n == 8 && cap_eof[3] && !cap_bad[3] && cap_sof[4] && cap_eof[7] && !cap_bad[7],
            "R10 shared flag tags", cap_n, 8);

        // R11: repeated flags alone
        cap_n = 0;
        for (int i = 0; i < 4; i++) send_flag();
        pause(3);
        chk(cap_n == 0, "R11 flags only", cap_n, 0);

        // R7 / R8: abort after six bytes
        ab0 = abort_cnt;
        cap_n = 0;
        send_flag();
        for (int k = 0; k < 6; k++)
            for (int i = 0; i < 8; i++) send_stuffed(((k * 37 + 11) >> i) & 1);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        pause(3);
        chk(abort_cnt == ab0 + 1, "R8 abort pulse after long frame", abort_cnt - ab0, 1);
        chk(cap_n > 0 && cap_eof[cap_n-1] && cap_bad[cap_n-1], "R7 abort closes frame bad",
            cap_n, 5);

        // R8: abort after only two bytes
        ab0 = abort_cnt;
        send_flag();
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 8; i++) send_stuffed(((k * 53 + 6) >> i) & 1);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        pause(3);
        chk(abort_cnt == ab0, "R8 no pulse for short abort", abort_cnt - ab0, 0);

        // R7: after abort, bits without a flag give nothing; then a frame is received
        cap_n = 0;
        for (int i = 0; i < 24; i++) send_bit(i % 3 == 0);
        pause(3);
        chk(cap_n == 0, "R7 hunting after abort", cap_n, 0);
        tx[0] = 8'h77; tx[1] = 8'h88; tx_n = 2;
        one_frame(0);
        check_frame(1, 0, "R7 recovery frame");

        // R9: idle threshold
        send_bit(1'b0);
        for (int i = 0; i < 14; i++) send_bit(1'b1);
        pause(1);
        chk(line_idle === 1'b0, "R9 fourteen ones", int'(line_idle), 0);
        send_bit(1'b1);
        pause(1);
        chk(line_idle === 1'b1, "R9 fifteen ones", int'(line_idle), 1);
        send_bit(1'b1);
        send_bit(1'b1);
        pause(1);
        chk(line_idle === 1'b1, "R9 more ones", int'(line_idle), 1);
        send_bit(1'b0);
        pause(1);
        chk(line_idle === 1'b0, "R9 zero clears", int'(line_idle), 0);

        // R6: six-bit mode has no effect with the filter off
        addr_filt_en = 1'b0; addr_six_bit = 1'b1; my_addr = 8'h10;
        tx[0] = 8'h6A; tx[1] = 8'h3C; tx_n = 2;
        one_frame(0);
        check_frame(1, 0, "R6 six-bit ignored when filter off");

        // R5 / R6: sweep every address value in both compare modes
        addr_filt_en = 1'b1;
        my_addr = 8'h5B;
        for (int m = 0; m < 2; m++) begin
            addr_six_bit = m[0];
            for (int a = 0; a < 256; a++) begin
                bit exp_acc;
                int sh;
                sh = (m == 1) ? 2 : 1;
                exp_acc = (a == 255) || ((a >> sh) == (8'h5B >> sh));
                tx[0] = a[7:0]; tx[1] = 8'h3C; tx_n = 2;
                one_frame(0);
                chk(cap_n == (exp_acc ? 4 : 0) &&
                    (!exp_acc || (cap_d[0] == a[7:0] && !cap_bad[3])),
                    (m == 1) ? "R6 six-bit filter" : "R5 seven-bit filter",
                    cap_n, exp_acc ? 4 : 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule